// File: doc/BRIEF.md
# Kernel Launch and Interrupt Register Block

This block is an AXI4-Lite slave that sits between a processor and a compute kernel. Software uses it to hand the kernel four 32-bit buffer addresses, to start a run, to watch the kernel's progress, and to take an interrupt when a run finishes or when the kernel is ready for its next start. Each control bit has its own access rule. The start bit clears itself when the kernel acknowledges it. The done flag stays set until software reads the control word. Pending interrupt flags flip when software writes a 1 to them.

The kernel side has a start level out, a done pulse in, a live idle level in and a ready pulse in. With the auto-restart option set, the block restarts the kernel after every accepted start, and the kernel runs back to back without software. One level interrupt output combines the pending flags behind a global enable.

Top module: `kctl_regfile`

## Requirements
- R1: After reset, `kern_start` and `irq` are 0, `s_bvalid` and `s_rvalid` are 0, and every stored register reads 0. The control word then shows only the live idle and ready inputs.
- R2: A write completes whether its address comes before its data, after it, or in the same cycle. It produces exactly one response with code 0 (OKAY). `s_bvalid` stays high until `s_bready` is seen, and no new address or data is accepted while it is high.
- R3: A read returns its word with code 0 on the cycle after the address handshake. `s_rvalid` and `s_rdata` hold until `s_rready` is seen.
- R4: Writing a 1 to bit 0 of the control word at offset 0x00 raises `kern_start`. Writing a 0 there does not lower it. A cycle with `kern_start` and `kern_ready` both high lowers it on the next edge when auto-restart is off.
- R5: Bit 7 of the control word is auto-restart (read/write). While it is 1, `kern_start` stays high through each `kern_ready` handshake.
- R6: Bit 1 of the control word (done) is set on any cycle that `kern_done` is high. A read of offset 0x00 returns it and then clears it. A new `kern_done` in the same cycle as that read wins.
- R7: Bit 2 of the control word shows `kern_idle`, and bit 3 shows `kern_ready`, both as sampled in the read handshake cycle.
- R8: Bit 0 at offset 0x04 is the global interrupt enable. Bits 1:0 at offset 0x08 enable the interrupt channels: bit 0 for done and bit 1 for ready. Both registers read back what was written.
- R9: Offset 0x0C holds the pending flags, bit 0 for done and bit 1 for ready. A flag is set in any cycle its kernel input is high while its channel enable is 1. Writing a 1 to a flag inverts it.
- R10: `irq` is high one cycle after the global enable is 1 and at least one pending flag is set, and low otherwise.
- R11: Argument words k = 0..3 sit at offsets 0x10, 0x18, 0x20 and 0x28. Each is written byte by byte under `s_wstrb`, is readable, and drives bits [32k+31:32k] of `arg_bus`.
- R12: Offsets 0x14, 0x1C, 0x24, 0x2C, 0x30 to 0x3C and unused bits read as 0 with an OKAY response. Writes to these offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 6 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| kern_start | output | 1 | Start level to the kernel |
| kern_done | input | 1 | Kernel finished pulse |
| kern_idle | input | 1 | Kernel idle level |
| kern_ready | input | 1 | Kernel accepted start pulse |
| arg_bus | output | 128 | Four argument words, word k at bits 32k+31:32k |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is the control bits changing on a kernel event while a bus transaction is still in flight. Examples are the ready flag showing in a control read, and the start bit surviving a handshake with auto-restart set. The stimulus holds `kern_ready` high across a whole read so that the sampled word must carry bit 3. It pulses `kern_ready` for exactly one cycle between register writes so that the start bit's fate rests on a single handshake edge. Write transactions are issued with address first, data first and both together, and responses are held back with `s_bready` low, which covers every branch of the write channel holding logic.

// File: rtl/kctl_pkg.sv
`timescale 1ns/1ps
package kctl_pkg;
   localparam logic [1:0] RESP_OK = 2'b00;
   // word indices (byte offset / 4)
   localparam int WI_CTRL = 0;
   localparam int WI_GIE  = 1;
   localparam int WI_IER  = 2;
   localparam int WI_ISR  = 3;
   localparam int WI_ARG0 = 4;
   localparam int ARG_STEP = 2;
   // control word bit positions
   localparam int CB_START = 0;
   localparam int CB_DONE  = 1;
   localparam int CB_IDLE  = 2;
   localparam int CB_READY = 3;
   localparam int CB_AUTO  = 7;

   function automatic int arg_word(input int k);
      return WI_ARG0 + ARG_STEP * k;
   endfunction
endpackage

// File: rtl/kctl_axil_wr.sv
`timescale 1ns/1ps
module kctl_axil_wr #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8,
   localparam int IDX_W  = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   output logic              wr_fire,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb
);
   logic              aw_held, w_held;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] data_q;
   logic [STRB_W-1:0] strb_q;
   logic              aw_hs, w_hs;

   assign awready = !aw_held && !bvalid;
   assign wready  = !w_held && !bvalid;
   assign aw_hs   = awvalid && awready;
   assign w_hs    = wvalid && wready;
   assign wr_fire = (aw_held || aw_hs) && (w_held || w_hs);
   assign wr_idx  = aw_held ? idx_q  : awaddr[ADDR_W-1:2];
   assign wr_data = w_held  ? data_q : wdata;
   assign wr_strb = w_held  ? strb_q : wstrb;
   assign bresp   = kctl_pkg::RESP_OK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_held <= 1'b0;
         w_held  <= 1'b0;
         bvalid  <= 1'b0;
         idx_q   <= '0;
         data_q  <= '0;
         strb_q  <= '0;
      end else begin
         if (wr_fire) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
         end else begin
            if (aw_hs) begin
               aw_held <= 1'b1;
               idx_q   <= awaddr[ADDR_W-1:2];
            end
            if (w_hs) begin
               w_held <= 1'b1;
               data_q <= wdata;
               strb_q <= wstrb;
            end
         end
         if (bvalid && bready) bvalid <= 1'b0;
         if (wr_fire)          bvalid <= 1'b1;
      end
   end
endmodule

// File: rtl/kctl_axil_rd.sv
`timescale 1ns/1ps
module kctl_axil_rd #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   localparam int IDX_W = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   output logic              rd_fire,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_word
);
   assign arready = !rvalid;
   assign rd_fire = arvalid && arready;
   assign rd_idx  = araddr[ADDR_W-1:2];
   assign rresp   = kctl_pkg::RESP_OK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else if (rd_fire) begin
         rvalid <= 1'b1;
         rdata  <= rd_word;
      end else if (rready) begin
         rvalid <= 1'b0;
      end
   end
endmodule

// File: rtl/kctl_hs_ctrl.sv
`timescale 1ns/1ps
module kctl_hs_ctrl #(
   parameter int  IDX_W   = 4,
   parameter int  DATA_W  = 32,
   parameter bit  IRQ_REG = 1'b1,
   localparam int STRB_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic              rd_fire,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              kern_done,
   input  logic              kern_ready,
   output logic              start_q,
   output logic              auto_q,
   output logic              done_q,
   output logic              gie_q,
   output logic [1:0]        ier_q,
   output logic [1:0]        isr_q,
   output logic              irq
);
   import kctl_pkg::*;
   logic       lo_wr;
   logic       wr_ctrl, wr_gie, wr_ier, wr_isr;
   logic [1:0] toggle, events;
   logic       irq_next;

   assign lo_wr   = wr_fire && wr_strb[0];
   assign wr_ctrl = lo_wr && (wr_idx == IDX_W'(WI_CTRL));
   assign wr_gie  = lo_wr && (wr_idx == IDX_W'(WI_GIE));
   assign wr_ier  = lo_wr && (wr_idx == IDX_W'(WI_IER));
   assign wr_isr  = lo_wr && (wr_idx == IDX_W'(WI_ISR));
   assign toggle  = wr_isr ? wr_data[1:0] : 2'b00;
   assign events  = ier_q & {kern_ready, kern_done};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         auto_q  <= 1'b0;
         done_q  <= 1'b0;
         gie_q   <= 1'b0;
         ier_q   <= '0;
         isr_q   <= '0;
      end else begin
         if (wr_ctrl && wr_data[CB_START]) start_q <= 1'b1;
         else if (start_q && kern_ready)   start_q <= auto_q;
         if (wr_ctrl) auto_q <= wr_data[CB_AUTO];
         if (kern_done) done_q <= 1'b1;
         else if (rd_fire && rd_idx == IDX_W'(WI_CTRL)) done_q <= 1'b0;
         if (wr_gie) gie_q <= wr_data[0];
         if (wr_ier) ier_q <= wr_data[1:0];
         isr_q <= (isr_q ^ toggle) | events;
      end
   end

   assign irq_next = gie_q && (isr_q != 2'b00);

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_next;
         end
      end else begin : g_irq_comb
         assign irq = irq_next;
      end
   endgenerate
endmodule

// File: rtl/kctl_regfile.sv
`timescale 1ns/1ps
module kctl_regfile #(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 32,
   parameter int N_ARG   = 4,
   parameter bit IRQ_REG = 1'b1,
   localparam int STRB_W = DATA_W / 8,
   localparam int IDX_W  = ADDR_W - 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       s_awaddr,
   input  logic                    s_awvalid,
   output logic                    s_awready,
   input  logic [DATA_W-1:0]       s_wdata,
   input  logic [STRB_W-1:0]       s_wstrb,
   input  logic                    s_wvalid,
   output logic                    s_wready,
   output logic [1:0]              s_bresp,
   output logic                    s_bvalid,
   input  logic                    s_bready,
   input  logic [ADDR_W-1:0]       s_araddr,
   input  logic                    s_arvalid,
   output logic                    s_arready,
   output logic [DATA_W-1:0]       s_rdata,
   output logic [1:0]              s_rresp,
   output logic                    s_rvalid,
   input  logic                    s_rready,
   output logic                    kern_start,
   input  logic                    kern_done,
   input  logic                    kern_idle,
   input  logic                    kern_ready,
   output logic [N_ARG*DATA_W-1:0] arg_bus,
   output logic                    irq
);
   import kctl_pkg::*;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("kctl_regfile: DATA_W must be 32");
      end
      if (N_ARG < 1 || arg_word(N_ARG - 1) >= (1 << IDX_W)) begin : g_bad_map
         $error("kctl_regfile: argument words do not fit the address space");
      end
   endgenerate

   logic              wr_fire, rd_fire;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, rd_word;
   logic [STRB_W-1:0] wr_strb;
   logic              start_q, auto_q, done_q, gie_q;
   logic [1:0]        ier_q, isr_q;
   logic [DATA_W-1:0] arg_q [N_ARG];

   kctl_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
   );

   kctl_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
      .clk(clk), .rst_n(rst_n),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .rd_fire(rd_fire), .rd_idx(rd_idx), .rd_word(rd_word)
   );

   kctl_hs_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) i_hs (
      .clk(clk), .rst_n(rst_n),
      .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_fire(rd_fire), .rd_idx(rd_idx),
      .kern_done(kern_done), .kern_ready(kern_ready),
      .start_q(start_q), .auto_q(auto_q), .done_q(done_q), .gie_q(gie_q),
      .ier_q(ier_q), .isr_q(isr_q), .irq(irq)
   );

   assign kern_start = start_q;

   generate
      for (genvar k = 0; k < N_ARG; k++) begin : g_arg
         logic hit;
         assign hit = wr_fire && (wr_idx == IDX_W'(arg_word(k)));
         for (genvar b = 0; b < STRB_W; b++) begin : g_byte
            always_ff @(posedge clk) begin
               if (!rst_n)                 arg_q[k][8*b +: 8] <= '0;
               else if (hit && wr_strb[b]) arg_q[k][8*b +: 8] <= wr_data[8*b +: 8];
            end
         end
         assign arg_bus[DATA_W*k +: DATA_W] = arg_q[k];
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      if (rd_idx == IDX_W'(WI_CTRL)) begin
         rd_word[CB_START] = start_q;
         rd_word[CB_DONE]  = done_q;
         rd_word[CB_IDLE]  = kern_idle;
         rd_word[CB_READY] = kern_ready;
         rd_word[CB_AUTO]  = auto_q;
      end else if (rd_idx == IDX_W'(WI_GIE)) begin
         rd_word[0] = gie_q;
      end else if (rd_idx == IDX_W'(WI_IER)) begin
         rd_word[1:0] = ier_q;
      end else if (rd_idx == IDX_W'(WI_ISR)) begin
         rd_word[1:0] = isr_q;
      end
      for (int k = 0; k < N_ARG; k++) begin
         if (rd_idx == IDX_W'(arg_word(k))) rd_word = arg_q[k];
      end
   end
endmodule

// File: rtl/kctl_regfile_chk.sv
`timescale 1ns/1ps
module kctl_regfile_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_awready,
   input logic              s_wready,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [DATA_W-1:0] s_rdata,
   input logic              kern_start,
   input logic              kern_done,
   input logic              kern_ready,
   input logic              wr_fire,
   input logic              auto_q,
   input logic              done_q,
   input logic              gie_q,
   input logic              irq
);
   // R2: response held until taken
   a_r2_bresp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid && !s_bready |=> s_bvalid);
   // R2: nothing accepted while a response is pending
   a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> !s_awready && !s_wready);
   // R3: read data held until taken
   a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
   // R4: handshake clears start
   a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kern_start && kern_ready && !auto_q && !wr_fire |=> !kern_start);
   // R5: auto-restart keeps start high
   a_r5_auto_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      kern_start && kern_ready && auto_q |=> kern_start);
   // R6: done latches
   a_r6_done_latch: assert property (@(posedge clk) disable iff (!rst_n)
      kern_done |=> done_q);
   // R10: no interrupt while globally disabled
   a_r10_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_q && $past(!gie_q) |-> !irq);
endmodule

bind kctl_regfile kctl_regfile_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n),
   .s_awready(s_awready), .s_wready(s_wready),
   .s_bvalid(s_bvalid), .s_bready(s_bready),
   .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
   .kern_start(kern_start), .kern_done(kern_done), .kern_ready(kern_ready),
   .wr_fire(wr_fire), .auto_q(auto_q), .done_q(done_q), .gie_q(gie_q),
   .irq(irq)
);

// File: tb/test_kctl_regfile.sv
`timescale 1ns/1ps
module test_kctl_regfile;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [5:0]   s_awaddr = '0;
   logic         s_awvalid = 1'b0;
   logic         s_awready;
   logic [31:0]  s_wdata = '0;
   logic [3:0]   s_wstrb = '0;
   logic         s_wvalid = 1'b0;
   logic         s_wready;
   logic [1:0]   s_bresp;
   logic         s_bvalid;
   logic         s_bready = 1'b0;
   logic [5:0]   s_araddr = '0;
   logic         s_arvalid = 1'b0;
   logic         s_arready;
   logic [31:0]  s_rdata;
   logic [1:0]   s_rresp;
   logic         s_rvalid;
   logic         s_rready = 1'b0;
   logic         kern_start;
   logic         kern_done = 1'b0;
   logic         kern_idle = 1'b1;
   logic         kern_ready = 1'b0;
   logic [127:0] arg_bus;
   logic         irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   kctl_regfile i_kctl_regfile (.*);

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // order: 0 together, 1 address first, 2 data first; bdly cycles of held response
   task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] st,
                     input int order, input int bdly);
      @(negedge clk);
      if (order == 1) begin
         s_awaddr = a; s_awvalid = 1'b1;
         while (!s_awready) @(negedge clk);
         @(posedge clk); #1 s_awvalid = 1'b0;
         @(negedge clk);
      end else if (order == 2) begin
         s_wdata = d; s_wstrb = st; s_wvalid = 1'b1;
         while (!s_wready) @(negedge clk);
         @(posedge clk); #1 s_wvalid = 1'b0;
         @(negedge clk);
      end
      if (order != 1) begin s_awaddr = a; s_awvalid = 1'b1; end
      if (order != 2) begin s_wdata = d; s_wstrb = st; s_wvalid = 1'b1; end
      while (!((s_awready || !s_awvalid) && (s_wready || !s_wvalid))) @(negedge clk);
      @(posedge clk); #1 begin s_awvalid = 1'b0; s_wvalid = 1'b0; end
      @(negedge clk);
      while (!s_bvalid) @(negedge clk);
      for (int i = 0; i < bdly; i++) begin
         @(negedge clk);
         chk("R2 bvalid held", s_bvalid, 1'b1);
         chk("R2 awready low while busy", s_awready, 1'b0);
      end
      chk("R2 bresp okay", s_bresp, 2'b00);
      s_bready = 1'b1;
      @(posedge clk); #1 s_bready = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input int rdly, output logic [31:0] d);
      @(negedge clk);
      s_araddr = a; s_arvalid = 1'b1;
      while (!s_arready) @(negedge clk);
      @(posedge clk); #1 s_arvalid = 1'b0;
      @(negedge clk);
      chk("R3 rvalid next cycle", s_rvalid, 1'b1);
      d = s_rdata;
      for (int i = 0; i < rdly; i++) begin
         @(negedge clk);
         chk("R3 rvalid held", s_rvalid, 1'b1);
         chk("R3 rdata stable", s_rdata, d);
      end
      chk("R3 rresp okay", s_rresp, 2'b00);
      s_rready = 1'b1;
      @(posedge clk); #1 s_rready = 1'b0;
   endtask

   task automatic pulse_ready();
      @(negedge clk) kern_ready = 1'b1;
      @(negedge clk) kern_ready = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk) kern_done = 1'b1;
      @(negedge clk) kern_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      @(negedge clk);
      chk("R1 start low", kern_start, 1'b0);
      chk("R1 irq low", irq, 1'b0);
      chk("R1 bvalid low", s_bvalid, 1'b0);
      chk("R1 rvalid low", s_rvalid, 1'b0);
      chk("R1 args zero", arg_bus, 128'h0);
      rd(6'h00, 0, d); chk("R1 R7 ctrl shows idle only", d, 32'h4);
      rd(6'h0C, 0, d); chk("R1 isr zero", d, 32'h0);
   endtask

   task automatic t_args();
      logic [31:0] d;
      wr(6'h10, 32'h1111_2222, 4'hF, 0, 0);
      wr(6'h18, 32'h3333_4444, 4'hF, 1, 0);
      wr(6'h20, 32'h5555_6666, 4'hF, 2, 0);
      wr(6'h28, 32'hAAAA_BBBB, 4'hF, 0, 0);
      wr(6'h28, 32'h0102_0304, 4'b0101, 1, 0);
      chk("R11 R2 arg bus", arg_bus, {32'hAA02_BB04, 32'h5555_6666, 32'h3333_4444, 32'h1111_2222});
      rd(6'h18, 0, d); chk("R11 readback word1", d, 32'h3333_4444);
      rd(6'h28, 0, d); chk("R11 byte strobes", d, 32'hAA02_BB04);
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      wr(6'h14, 32'hDEAD_BEEF, 4'hF, 0, 0);
      wr(6'h3C, 32'hDEAD_BEEF, 4'hF, 2, 0);
      chk("R12 args untouched", arg_bus, {32'hAA02_BB04, 32'h5555_6666, 32'h3333_4444, 32'h1111_2222});
      rd(6'h14, 0, d); chk("R12 reserved reads zero", d, 32'h0);
      rd(6'h3C, 0, d); chk("R12 unmapped reads zero", d, 32'h0);
      rd(6'h04, 0, d); chk("R12 gie untouched", d, 32'h0);
   endtask

   task automatic t_hold();
      logic [31:0] d;
      wr(6'h10, 32'hCAFE_0001, 4'hF, 1, 3);
      rd(6'h10, 3, d); chk("R3 R2 held read data", d, 32'hCAFE_0001);
   endtask

   task automatic t_start();
      logic [31:0] d;
      wr(6'h00, 32'h1, 4'h1, 0, 0);
      @(negedge clk); chk("R4 start raised", kern_start, 1'b1);
      kern_idle = 1'b0;
      rd(6'h00, 0, d); chk("R4 R7 ctrl running", d, 32'h1);
      wr(6'h00, 32'h0, 4'h1, 0, 0);
      chk("R4 write zero keeps start", kern_start, 1'b1);
      pulse_ready();
      chk("R4 start cleared by handshake", kern_start, 1'b0);
      kern_idle = 1'b1;
      @(negedge clk) kern_ready = 1'b1;
      rd(6'h00, 0, d); chk("R7 ready bit live", d, 32'hC);
      @(negedge clk) kern_ready = 1'b0;
   endtask

   task automatic t_done();
      logic [31:0] d;
      pulse_done();
      rd(6'h00, 0, d); chk("R6 done latched", d, 32'h6);
      rd(6'h00, 0, d); chk("R6 done cleared by read", d, 32'h4);
   endtask

   task automatic t_auto();
      logic [31:0] d;
      wr(6'h00, 32'h81, 4'h1, 2, 0);
      pulse_ready();
      chk("R5 start kept by auto-restart", kern_start, 1'b1);
      pulse_ready();
      chk("R5 start kept after second handshake", kern_start, 1'b1);
      rd(6'h00, 0, d); chk("R5 ctrl auto bit", d, 32'h85);
      wr(6'h00, 32'h0, 4'h1, 0, 0);
      pulse_ready();
      chk("R5 start drops once auto is off", kern_start, 1'b0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(6'h08, 32'h3, 4'h1, 0, 0);
      rd(6'h08, 0, d); chk("R8 ier readback", d, 32'h3);
      pulse_done();
      rd(6'h0C, 0, d); chk("R9 done flag set", d, 32'h1);
      chk("R10 irq gated by global enable", irq, 1'b0);
      wr(6'h04, 32'h1, 4'h1, 1, 0);
      repeat (2) @(negedge clk);
      chk("R10 irq raised", irq, 1'b1);
      rd(6'h04, 0, d); chk("R8 gie readback", d, 32'h1);
      wr(6'h0C, 32'h1, 4'h1, 0, 0);
      repeat (2) @(negedge clk);
      rd(6'h0C, 0, d); chk("R9 toggle clears flag", d, 32'h0);
      chk("R10 irq dropped", irq, 1'b0);
      wr(6'h08, 32'h1, 4'h1, 0, 0);
      pulse_ready();
      rd(6'h0C, 0, d); chk("R9 disabled channel not flagged", d, 32'h0);
      wr(6'h0C, 32'h2, 4'h1, 2, 0);
      rd(6'h0C, 0, d); chk("R9 toggle sets flag", d, 32'h2);
      repeat (2) @(negedge clk);
      chk("R10 irq from ready flag", irq, 1'b1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_args();
      t_reserved();
      t_hold();
      t_start();
      t_done();
      t_auto();
      t_irq();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule